// File: doc/BRIEF.md
# Rotating Capacitor Role Sequencer

This block drives the switch enables of a switched-capacitor input stage that scales its input by a rational factor M_IN/N_CAP. Each input branch holds N_CAP equal capacitors. In every clock period of a conversion all of them take the feedback DAC charge, while only M_IN of them also sample the input. The set that samples the input moves by one capacitor position every period. Capacitor mismatch therefore shows up as periodic noise at the rotation rate instead of as a static gain error.

A one-cycle start strobe opens a conversion of CONV_LEN clock periods; 2048 by default. CONV_LEN need not be a multiple of N_CAP. Every conversion begins with the same role assignment. When the last period ends, the block raises a one-cycle end pulse, which the analog stage uses to reset its integrators. Outside a conversion all enables are held low. All outputs come straight from registers.

Top module: `cap_role_seq`

## Requirements
- R1: In every active period (run_o high), all N_CAP bits of dac_sel_o are 1.
- R2: In every active period, exactly M_IN bits of in_sel_o are 1. The defaults give 2 of 3.
- R3: In period index k, bit i of in_sel_o is 1 exactly when ((i - k) mod N_CAP) < M_IN. So period 0 has bits 0..M_IN-1 set, and each later period rotates the mask left by one position, with bit N_CAP-1 wrapping into bit 0.
- R4: Within every aligned window of N_CAP consecutive periods (k = jN_CAP .. jN_CAP+N_CAP-1), each capacitor is left out of input sampling exactly N_CAP-M_IN times.
- R5: When start_i is high at a rising edge, the next cycle shows run_o=1, period_o=0 and the period-0 mask. This also holds during a conversion, which restarts the conversion.
- R6: A conversion lasts CONV_LEN periods. While it runs, period_o counts 0, 1, … CONV_LEN-1, one step per cycle. CONV_LEN need not be a multiple of N_CAP.
- R7: conv_end_o is high for exactly one cycle, the cycle after period CONV_LEN-1. It stays low if a start strobe arrives at the edge that ends period CONV_LEN-1.
- R8: After reset and while idle, run_o, in_sel_o, dac_sel_o, period_o and conv_end_o are all 0 (conv_end_o except for its R7 pulse).
- R9: The same rules hold for any N_CAP >= 2 with 1 <= M_IN < N_CAP, for example 3 of 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion start strobe |
| run_o | output | 1 | High during the CONV_LEN active periods |
| in_sel_o | output | N_CAP | Per-capacitor input-sampling enables |
| dac_sel_o | output | N_CAP | Per-capacitor feedback-DAC enables |
| period_o | output | $clog2(CONV_LEN) | Index of the current period |
| conv_end_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Every output is one register away from start_i. A strobe seen at one edge therefore shows period 0 at the following edge, and period k appears k cycles after that. The end pulse appears CONV_LEN cycles after the period-0 edge. The bench drives start_i on the falling edge and samples outputs on falling edges only. After the strobe edge it walks exactly one falling edge per period and compares against a mask computed from the modular formula of R3. Restarts are issued on the falling edge that shows the target period, so the restart takes effect at the very next rising edge and is checked on the falling edge after it.

// File: rtl/crs_pkg.sv
package crs_pkg;

  localparam int MAX_CAP = 32;

  // Lowest m bits set: the role assignment of period 0.
  function automatic logic [MAX_CAP-1:0] base_mask(input int m);
    logic [MAX_CAP-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_CAP; i++) begin
      if (i < m) r[i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/crs_period_timer.sv
module crs_period_timer #(
  parameter int CONV_LEN = 2048,
  localparam int PW = $clog2(CONV_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          run_q,
  output logic [PW-1:0] period_q,
  output logic          end_q,
  output logic          load_o,
  output logic          step_o,
  output logic          clear_o
);

  localparam logic [PW-1:0] LAST = PW'(CONV_LEN - 1);

  logic at_last;

  assign at_last = (period_q == LAST);
  assign load_o  = start_i;
  assign step_o  = run_q && !at_last && !start_i;
  assign clear_o = run_q && at_last && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      period_q <= '0;
      end_q    <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (load_o) begin
        run_q    <= 1'b1;
        period_q <= '0;
      end else if (clear_o) begin
        run_q    <= 1'b0;
        period_q <= '0;
        end_q    <= 1'b1;
      end else if (step_o) begin
        period_q <= period_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crs_mask_rotator.sv
module crs_mask_rotator
  import crs_pkg::*;
#(
  parameter int N_CAP = 3,
  parameter int M_IN  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [N_CAP-1:0] mask_q
);

  localparam logic [MAX_CAP-1:0] BASE_W = base_mask(M_IN);
  localparam logic [N_CAP-1:0]   BASE   = BASE_W[N_CAP-1:0];

  logic [N_CAP-1:0] rotated;

  // Left rotation by one: bit i takes the value of bit i-1, wrapping.
  for (genvar i = 0; i < N_CAP; i++) begin : g_rot
    assign rotated[i] = mask_q[(i + N_CAP - 1) % N_CAP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (load_i) begin
      mask_q <= BASE;
    end else if (clear_i) begin
      mask_q <= '0;
    end else if (step_i) begin
      mask_q <= rotated;
    end
  end

endmodule

// File: rtl/crs_dac_drive.sv
module crs_dac_drive #(
  parameter int N_CAP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             clear_i,
  output logic [N_CAP-1:0] dac_q
);

  // One flop per capacitor so each enable sits next to its switch.
  for (genvar i = 0; i < N_CAP; i++) begin : g_dac
    always_ff @(posedge clk) begin
      if (rst) begin
        dac_q[i] <= 1'b0;
      end else if (load_i) begin
        dac_q[i] <= 1'b1;
      end else if (clear_i) begin
        dac_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cap_role_seq.sv
module cap_role_seq #(
  parameter int N_CAP    = 3,
  parameter int M_IN     = 2,
  parameter int CONV_LEN = 2048,
  localparam int PW = $clog2(CONV_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             run_o,
  output logic [N_CAP-1:0] in_sel_o,
  output logic [N_CAP-1:0] dac_sel_o,
  output logic [PW-1:0]    period_o,
  output logic             conv_end_o
);

  logic load, step, clear;

  crs_period_timer #(.CONV_LEN(CONV_LEN)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .run_q    (run_o),
    .period_q (period_o),
    .end_q    (conv_end_o),
    .load_o   (load),
    .step_o   (step),
    .clear_o  (clear)
  );

  crs_mask_rotator #(.N_CAP(N_CAP), .M_IN(M_IN)) u_rot (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .step_i  (step),
    .clear_i (clear),
    .mask_q  (in_sel_o)
  );

  crs_dac_drive #(.N_CAP(N_CAP)) u_dac (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .clear_i (clear),
    .dac_q   (dac_sel_o)
  );

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int N_CAP    = 3,
  parameter int M_IN     = 2,
  parameter int CONV_LEN = 2048,
  localparam int PW = $clog2(CONV_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             run_o,
  input logic [N_CAP-1:0] in_sel_o,
  input logic [N_CAP-1:0] dac_sel_o,
  input logic [PW-1:0]    period_o,
  input logic             conv_end_o
);

  localparam logic [PW-1:0] LAST = PW'(CONV_LEN - 1);

  AST_DAC_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    run_o |-> (dac_sel_o == {N_CAP{1'b1}})); // R1

  AST_IN_COUNT: assert property (@(posedge clk) disable iff (rst)
    run_o |-> ($countones(in_sel_o) == M_IN)); // R2

  AST_ROTATE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (run_o && $past(run_o) && !$past(start_i)) |->
      (in_sel_o == {$past(in_sel_o[N_CAP-2:0]), $past(in_sel_o[N_CAP-1])})); // R3

  AST_START_BASE: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (run_o && period_o == '0 && $countones(in_sel_o[M_IN-1:0]) == M_IN)); // R5

  AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_o && $past(run_o) && !$past(start_i)) |->
      (period_o == $past(period_o) + PW'(1))); // R6

  AST_END_SOURCE: assert property (@(posedge clk) disable iff (rst)
    conv_end_o |-> ($past(run_o) && $past(period_o) == LAST && !$past(start_i))); // R7

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_end_o |=> !conv_end_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> (in_sel_o == '0 && dac_sel_o == '0 && period_o == '0)); // R8

endmodule

bind cap_role_seq crs_checker #(
  .N_CAP(N_CAP), .M_IN(M_IN), .CONV_LEN(CONV_LEN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .run_o      (run_o),
  .in_sel_o   (in_sel_o),
  .dac_sel_o  (dac_sel_o),
  .period_o   (period_o),
  .conv_end_o (conv_end_o)
);

// File: tb/tb_cap_role_seq.sv
module tb_cap_role_seq;

  localparam int N  = 3;
  localparam int M  = 2;
  localparam int L  = 2048;
  localparam int PW = $clog2(L);
  localparam int NG = 5;
  localparam int MG = 3;
  localparam int LG = 13;
  localparam int PWG = $clog2(LG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic start_g = 1'b0;

  logic          run;
  logic [N-1:0]  in_sel, dac_sel;
  logic [PW-1:0] period;
  logic          cend;

  logic           run_g;
  logic [NG-1:0]  in_sel_g, dac_sel_g;
  logic [PWG-1:0] period_g;
  logic           cend_g;

  int nchk = 0;
  int nfail = 0;
  int excl [N];

  always #4 clk = ~clk;

  cap_role_seq #(.N_CAP(N), .M_IN(M), .CONV_LEN(L)) dut (
    .clk(clk), .rst(rst), .start_i(start), .run_o(run), .in_sel_o(in_sel),
    .dac_sel_o(dac_sel), .period_o(period), .conv_end_o(cend)
  );

  cap_role_seq #(.N_CAP(NG), .M_IN(MG), .CONV_LEN(LG)) dut_g (
    .clk(clk), .rst(rst), .start_i(start_g), .run_o(run_g), .in_sel_o(in_sel_g),
    .dac_sel_o(dac_sel_g), .period_o(period_g), .conv_end_o(cend_g)
  );

  function automatic logic [31:0] exp_mask(input int k, input int n, input int m);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) begin
      if ((((i - k) % n) + n) % n < m) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({"R8 run ", tag}, run, 0);
    chk({"R8 in_sel ", tag}, in_sel, 0);
    chk({"R8 dac_sel ", tag}, dac_sel, 0);
    chk({"R8 period ", tag}, period, 0);
  endtask

  // Called on the falling edge that shows period k.
  task automatic check_period(input int k);
    if (k % N == 0) foreach (excl[i]) excl[i] = 0;
    chk("R6 run", run, 1);
    chk("R6 period", period, k);
    chk("R1 dac_sel", dac_sel, {N{1'b1}});
    chk("R2 count", $countones(in_sel), M);
    chk("R3 mask", in_sel, exp_mask(k, N, M));
    for (int i = 0; i < N; i++) if (!in_sel[i]) excl[i]++;
    if (k % N == N - 1) begin
      for (int i = 0; i < N; i++) chk("R4 exclusions", excl[i], N - M);
    end
  endtask

  task automatic walk(input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      check_period(k);
      @(negedge clk);
    end
  endtask

  task automatic pulse_start;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_end;
    chk("R7 end pulse", cend, 1);
    check_idle("after end");
    @(negedge clk);
    chk("R7 end single", cend, 0);
    check_idle("idle");
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_idle("reset");
    chk("R8 end reset", cend, 0);
  endtask

  task automatic t_full;
    pulse_start();
    walk(0, L - 1);
    check_end();
  endtask

  task automatic t_restart_mid;
    pulse_start();
    walk(0, 4);
    chk("R5 pre-restart period", period, 5);
    pulse_start();
    chk("R5 restart period", period, 0);
    chk("R5 restart mask", in_sel, exp_mask(0, N, M));
    chk("R5 restart end", cend, 0);
    walk(0, L - 1);
    check_end();
  endtask

  task automatic t_restart_last;
    pulse_start();
    walk(0, L - 2);
    check_period(L - 1);
    pulse_start();
    chk("R7 no end on restart", cend, 0);
    chk("R5 run", run, 1);
    walk(0, L - 1);
    check_end();
  endtask

  task automatic t_general;
    start_g = 1'b1;
    @(negedge clk);
    start_g = 1'b0;
    for (int k = 0; k < LG; k++) begin
      chk("R9 run", run_g, 1);
      chk("R9 period", period_g, k);
      chk("R9 dac", dac_sel_g, {NG{1'b1}});
      chk("R9 count", $countones(in_sel_g), MG);
      chk("R9 mask", in_sel_g, exp_mask(k, NG, MG));
      @(negedge clk);
    end
    chk("R9 end", cend_g, 1);
    chk("R9 idle mask", in_sel_g, 0);
    @(negedge clk);
    chk("R9 end single", cend_g, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_restart_mid();
    t_restart_last();
    t_general();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule